// File: doc/BRIEF.md
# Offset-Started Periodic Strobe Generator

This block produces a periodic one-clock strobe from a free-running radio frame timer. The timer position is given as four fields: slot, chip-length table index, chip and sub-chip. Together with the position comes a tick that marks each cycle in which the timer has moved on. A strobe generator stays idle until the timer lands on a programmed start position. From then on it counts qualifying ticks, which are ticks whose sub-chip equals the start sub-chip. It emits a strobe each time the count runs out and then starts counting again.

The period is programmed as a count value equal to the period minus one, so any period from 1 to 2^CNT_W qualifying ticks is available and need not be a power of two. The start position sets the phase. Two generators with the same count value but different start chips give strobes at the same rate with their phases apart by the chip difference. A typical setting is a count value of 31 with the start sub-chip at 0: the timer gives one qualifying tick per chip, so the strobe comes every 32 chips.

Top module: `cbeg_event_gen`

## Requirements
- R1: After synchronous reset, and while no start has happened, `event_o` is 0.
- R2: Counting begins only on a tick in which all four timer fields (slot, index, chip, sub-chip) equal the start fields. A matching chip and sub-chip in a different slot does not start the generator.
- R3: The tick that starts the generator is the first qualifying tick. The first strobe follows the qualifying tick that comes `cval_i` qualifying ticks later. Further strobes come every `cval_i`+1 qualifying ticks.
- R4: Only cycles with `tick_i`=1 and `tm_sub_i` equal to `of_sub_i` are qualifying. Cycles without a tick, and ticks at any other sub-chip, leave the count unchanged.
- R5: With `cval_i`=0 a strobe comes on every qualifying tick, including the start tick itself.
- R6: `event_o` is high in the single cycle after the edge that samples the completing tick. With `cval_i`>0 it is one cycle wide.
- R7: While `en_i`=0 no strobe is produced. The count and the started state are cleared at the next edge, so a completing tick that arrives during that cycle is lost. After re-enabling, the generator waits for the start position again.
- R8: The count completes when it has reached or passed `cval_i`. Lowering `cval_i` below the present count therefore gives a strobe on the next qualifying tick.
- R9: Two runs with equal `cval_i`=31 and start chips 0 and 12 give strobes at a period of 32 chips. The second run's strobes fall 12 chips later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Generator enable |
| tick_i | input | 1 | Timer moved on this cycle; the fields below are valid |
| tm_slot_i | input | 4 | Timer slot |
| tm_idx_i | input | 2 | Timer chip-length table index |
| tm_chip_i | input | 12 | Timer chip |
| tm_sub_i | input | 3 | Timer sub-chip |
| of_slot_i | input | 4 | Start slot |
| of_idx_i | input | 2 | Start table index |
| of_chip_i | input | 12 | Start chip |
| of_sub_i | input | 3 | Start sub-chip, also the qualifying sub-chip |
| cval_i | input | 8 | Period minus one, in qualifying ticks |
| event_o | output | 1 | One-cycle strobe |

## Verification
Two functions can act on the same tick: starting at the programmed position, and completing the count. With `cval_i`=0 the start tick must also give the strobe. The bench checks this by logging the chip of the first strobe and requiring it to equal the start chip. A second overlap is a disable that arrives on the completing tick. For this case the bench drops `en_i` across the chip where the strobe was due and requires that no strobe appears, then that the next one needs a fresh start and a full period.

// File: rtl/cbeg_pkg.sv
`timescale 1ns/1ps
package cbeg_pkg;
    parameter int SUB_W  = 3;
    parameter int IDX_W  = 2;
    parameter int CHIP_W = 12;
    parameter int SLOT_W = 4;

    localparam int POS_W = SUB_W + IDX_W + CHIP_W + SLOT_W;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [IDX_W-1:0]  idx;
        logic [CHIP_W-1:0] chip;
        logic [SUB_W-1:0]  sub;
    } tpos_t;

    typedef enum logic [0:0] {
        ARM_IDLE = 1'b0,
        ARM_RUN  = 1'b1
    } arm_st_t;

    function automatic tpos_t pack_pos(
        input logic [SLOT_W-1:0] slot,
        input logic [IDX_W-1:0]  idx,
        input logic [CHIP_W-1:0] chip,
        input logic [SUB_W-1:0]  sub
    );
        tpos_t p;
        p.slot = slot;
        p.idx  = idx;
        p.chip = chip;
        p.sub  = sub;
        return p;
    endfunction

    function automatic logic sub_equal(input tpos_t a, input tpos_t b);
        return a.sub == b.sub;
    endfunction
endpackage

// File: rtl/cbeg_pos_match.sv
`timescale 1ns/1ps
module cbeg_pos_match
    import cbeg_pkg::*;
(
    input  tpos_t now_i,
    input  tpos_t off_i,
    output logic  sub_hit_o,
    output logic  pos_hit_o
);
    localparam int NFLD = 4;
    logic [NFLD-1:0] fld_eq;

    generate
        for (genvar g = 0; g < NFLD; g++) begin : g_fld
            if (g == 0) begin : g_sub
                assign fld_eq[g] = sub_equal(now_i, off_i);
            end else if (g == 1) begin : g_chip
                assign fld_eq[g] = (now_i.chip == off_i.chip);
            end else if (g == 2) begin : g_idx
                assign fld_eq[g] = (now_i.idx == off_i.idx);
            end else begin : g_slot
                assign fld_eq[g] = (now_i.slot == off_i.slot);
            end
        end
    endgenerate

    assign sub_hit_o = fld_eq[0];
    assign pos_hit_o = &fld_eq;
endmodule

// File: rtl/cbeg_arm.sv
`timescale 1ns/1ps
module cbeg_arm
    import cbeg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic tick_i,
    input  logic sub_hit_i,
    input  logic pos_hit_i,
    output logic armed_o,
    output logic start_o,
    output logic qual_o
);
    arm_st_t st_q;

    assign start_o = en_i && tick_i && pos_hit_i;
    assign qual_o  = en_i && tick_i && sub_hit_i && ((st_q == ARM_RUN) || pos_hit_i);
    assign armed_o = (st_q == ARM_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ARM_IDLE;
        end else if (!en_i) begin
            st_q <= ARM_IDLE;
        end else if (start_o) begin
            st_q <= ARM_RUN;
        end
    end
endmodule

// File: rtl/cbeg_period_ctr.sv
`timescale 1ns/1ps
module cbeg_period_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             qual_i,
    input  logic [CNT_W-1:0] cval_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;

    assign done_o = (cnt_q >= cval_i);
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!en_i) begin
            cnt_q <= '0;
        end else if (qual_i) begin
            cnt_q <= done_o ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cbeg_event_gen.sv
`timescale 1ns/1ps
module cbeg_event_gen
    import cbeg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              tick_i,
    input  logic [SLOT_W-1:0] tm_slot_i,
    input  logic [IDX_W-1:0]  tm_idx_i,
    input  logic [CHIP_W-1:0] tm_chip_i,
    input  logic [SUB_W-1:0]  tm_sub_i,
    input  logic [SLOT_W-1:0] of_slot_i,
    input  logic [IDX_W-1:0]  of_idx_i,
    input  logic [CHIP_W-1:0] of_chip_i,
    input  logic [SUB_W-1:0]  of_sub_i,
    input  logic [CNT_W-1:0]  cval_i,
    output logic              event_o
);
    tpos_t            now_pos;
    tpos_t            off_pos;
    logic             sub_hit;
    logic             pos_hit;
    logic             armed_w;
    logic             start_w;
    logic             qual_w;
    logic [CNT_W-1:0] cnt_w;
    logic             done_w;
    logic             evt_q;

    assign now_pos = pack_pos(tm_slot_i, tm_idx_i, tm_chip_i, tm_sub_i);
    assign off_pos = pack_pos(of_slot_i, of_idx_i, of_chip_i, of_sub_i);

    cbeg_pos_match u_match (
        .now_i     (now_pos),
        .off_i     (off_pos),
        .sub_hit_o (sub_hit),
        .pos_hit_o (pos_hit)
    );

    cbeg_arm u_arm (
        .clk       (clk),
        .rst       (rst),
        .en_i      (en_i),
        .tick_i    (tick_i),
        .sub_hit_i (sub_hit),
        .pos_hit_i (pos_hit),
        .armed_o   (armed_w),
        .start_o   (start_w),
        .qual_o    (qual_w)
    );

    cbeg_period_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .en_i   (en_i),
        .qual_i (qual_w),
        .cval_i (cval_i),
        .cnt_o  (cnt_w),
        .done_o (done_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= 1'b0;
        end else begin
            evt_q <= en_i && qual_w && done_w;
        end
    end

    assign event_o = evt_q;
endmodule

// File: rtl/cbeg_event_gen_chk.sv
`timescale 1ns/1ps
module cbeg_event_gen_chk #(
    parameter int CNT_W = 8,
    parameter int SUB_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             tick,
    input logic [SUB_W-1:0] tm_sub,
    input logic [SUB_W-1:0] of_sub,
    input logic             start,
    input logic             armed,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cval,
    input logic             evt
);
    p_evt_after_tick_r6: assert property (@(posedge clk) disable iff (rst)
        evt |-> $past(en && tick && (tm_sub == of_sub)));

    p_dis_clears_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!evt && !armed && (cnt == '0)));

    p_arm_on_start_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(start));

    p_hold_nonqual_r4: assert property (@(posedge clk) disable iff (rst)
        (en && !(tick && (tm_sub == of_sub))) |=> $stable(cnt));

    p_evt_on_done_r3: assert property (@(posedge clk) disable iff (rst)
        evt |-> $past(cnt >= cval));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (!armed && !start) |=> !evt);
endmodule

bind cbeg_event_gen cbeg_event_gen_chk #(.CNT_W(CNT_W), .SUB_W(cbeg_pkg::SUB_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .en     (en_i),
    .tick   (tick_i),
    .tm_sub (tm_sub_i),
    .of_sub (of_sub_i),
    .start  (start_w),
    .armed  (armed_w),
    .cnt    (cnt_w),
    .cval   (cval_i),
    .evt    (event_o)
);

// File: tb/cbeg_event_gen_tb.sv
`timescale 1ns/1ps
module cbeg_event_gen_tb;
    localparam int CHIP_LAST = 2559;
    localparam int SLOT_LAST = 14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        tick = 1'b0;
    logic [3:0]  tm_slot = '0, of_slot = '0;
    logic [1:0]  tm_idx = '0,  of_idx = '0;
    logic [11:0] tm_chip = '0, of_chip = '0;
    logic [2:0]  tm_sub = '0,  of_sub = '0;
    logic [7:0]  cval = '0;
    logic        event_o;

    int  t_slot, t_chip, t_sub;
    int  n_chk = 0, n_fail = 0;
    int  ref_cnt;
    bit  ref_armed;
    int  ev_n, run_len, max_run;
    int  ev_chip [16];
    string cur_req = "R1";
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    cbeg_event_gen u_dut (
        .clk(clk), .rst(rst), .en_i(en), .tick_i(tick),
        .tm_slot_i(tm_slot), .tm_idx_i(tm_idx), .tm_chip_i(tm_chip), .tm_sub_i(tm_sub),
        .of_slot_i(of_slot), .of_idx_i(of_idx), .of_chip_i(of_chip), .of_sub_i(of_sub),
        .cval_i(cval), .event_o(event_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_log();
        ev_n = 0; run_len = 0; max_run = 0;
    endtask

    task automatic set_timer(input int s, input int c, input int b);
        t_slot = s; t_chip = c; t_sub = b;
    endtask

    task automatic set_off(input int s, input int c, input int b, input int cv);
        of_slot = 4'(s); of_idx = '0; of_chip = 12'(c); of_sub = 3'(b); cval = 8'(cv);
    endtask

    // One clock: drive inputs, predict, sample after the edge.
    task automatic step(input bit tk);
        bit hit, start, q, exp;
        int dchip;
        tick = tk; tm_slot = 4'(t_slot); tm_idx = '0; tm_chip = 12'(t_chip); tm_sub = 3'(t_sub);
        dchip = t_chip;
        hit   = tk && (t_sub == int'(of_sub));
        start = hit && (t_slot == int'(of_slot)) && (t_chip == int'(of_chip)) && (of_idx == 2'd0);
        q     = en && hit && (ref_armed || start);
        exp   = q && (ref_cnt >= int'(cval));
        if (!en) begin
            ref_armed = 1'b0; ref_cnt = 0;
        end else begin
            if (start) ref_armed = 1'b1;
            if (q) ref_cnt = exp ? 0 : ref_cnt + 1;
        end
        @(posedge clk); #1;
        check({cur_req, " strobe per cycle"}, int'(event_o), int'(exp));
        if (event_o) begin
            if (ev_n < 16) ev_chip[ev_n] = dchip;
            ev_n++; run_len++;
            if (run_len > max_run) max_run = run_len;
        end else begin
            run_len = 0;
        end
        if (tk) begin
            if (t_sub == 7) begin
                t_sub = 0;
                if (t_chip == CHIP_LAST) begin
                    t_chip = 0;
                    t_slot = (t_slot == SLOT_LAST) ? 0 : t_slot + 1;
                end else t_chip++;
            end else t_sub++;
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(1'b1);
    endtask

    task automatic disable_gen();
        en = 1'b0; step(1'b0); en = 1'b1;
    endtask

    task automatic test_reset();
        cur_req = "R1";
        rst = 1'b1; ref_armed = 0; ref_cnt = 0;
        repeat (3) @(posedge clk);
        #1 check("R1 event low in reset", int'(event_o), 0);
        rst = 1'b0;
        clear_log(); set_timer(0, 0, 0); set_off(0, 2, 0, 0);
        run(24);
        check("R1 no strobe while disabled", ev_n, 0);
    endtask

    task automatic test_offset();
        cur_req = "R2";
        en = 1'b1; set_off(1, 5, 2, 3);
        clear_log(); set_timer(0, 0, 0); run(60);
        check("R2 other slot does not start", ev_n, 0);
        cur_req = "R3";
        clear_log(); set_timer(1, 0, 0); run(100);
        check("R3 strobe count", ev_n, 2);
        check("R3 first strobe chip", ev_chip[0], 8);
        check("R3 period in chips", ev_chip[1] - ev_chip[0], 4);
        check("R6 strobe width", max_run, 1);
        disable_gen();
    endtask

    task automatic test_qualify();
        cur_req = "R4";
        set_off(0, 3, 4, 2);
        clear_log(); set_timer(0, 0, 0);
        for (int i = 0; i < 192; i++) step(i % 2 == 0);
        check("R4 strobes with gapped ticks", ev_n, 3);
        check("R4 first strobe chip", ev_chip[0], 5);
        check("R4 spacing", ev_chip[2] - ev_chip[1], 3);
        disable_gen();
    endtask

    task automatic test_zero();
        cur_req = "R5";
        set_off(0, 2, 7, 0);
        clear_log(); set_timer(0, 0, 0); run(48);
        check("R5 strobe every qualifying tick", ev_n, 4);
        check("R5 start tick gives strobe", ev_chip[0], 2);
        disable_gen();
    endtask

    task automatic test_disable();
        cur_req = "R7";
        set_off(0, 1, 0, 3);
        clear_log(); set_timer(0, 0, 0); run(32);
        en = 1'b0;
        for (int i = 0; i < 3; i++) step(1'b1);
        check("R7 completing tick while disabled", ev_n, 0);
        en = 1'b1; run(80);
        check("R7 no strobe before new start", ev_n, 0);
        clear_log(); set_timer(0, 0, 0); run(48);
        check("R7 restart count", ev_n, 1);
        check("R7 restart full period chip", ev_chip[0], 4);
        disable_gen();
    endtask

    task automatic test_shrink();
        cur_req = "R8";
        set_off(0, 0, 0, 31);
        clear_log(); set_timer(0, 0, 0); run(88);
        check("R8 nothing before shrink", ev_n, 0);
        cval = 8'd2; run(16);
        check("R8 strobe after shrink", ev_n, 1);
        check("R8 strobe chip", ev_chip[0], 11);
        disable_gen();
    endtask

    task automatic test_phase();
        int a0, a1;
        cur_req = "R9";
        set_off(0, 0, 0, 31);
        clear_log(); set_timer(0, 0, 0); run(512);
        check("R9 first run strobes", ev_n, 2);
        a0 = ev_chip[0]; a1 = ev_chip[1];
        check("R9 32-chip period", a1 - a0, 32);
        disable_gen();
        set_off(0, 12, 0, 31);
        clear_log(); set_timer(0, 0, 0); run(608);
        check("R9 second run strobes", ev_n, 2);
        check("R9 same period", ev_chip[1] - ev_chip[0], 32);
        check("R9 phase offset", ev_chip[0] - a0, 12);
        disable_gen();
    endtask

    initial begin
        set_timer(0, 0, 0);
        clear_log();
        test_reset();
        test_offset();
        test_qualify();
        test_zero();
        test_disable();
        test_shrink();
        test_phase();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule